// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the 16-bit status word of an I2C controller that can act as bus master or as slave. The controller core does not write the word directly; it reports single-cycle event strobes (bus conditions such as Start, repeated Start and Stop, the end of each acknowledge slot, the start of a master transmission, arbitration loss, address matches, received bytes and host accesses to the holding registers). The block turns those strobes into flags according to fixed set, clear and priority rules. Every flag changes on the clock edge that samples its strobe, so the new value is visible on the read port one cycle after the strobe is raised.

Software sees the whole word on a plain read port at all times. It uses a separate write port only to clear the three sticky error flags, by writing 0 to their bit positions. Writes to any other bit have no effect. The block has no data stream. All of its pins are plain control and status signals, so it has no valid/ready handshake and no back-pressure.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset every bit of `rd_data_o` is 0, and bits 13, 12, 11 and 2 read 0 at all times.
- R2: Bit 15 (ack status) takes the value of `ack_nack_i` (1 = NACK, 0 = ACK) on each cycle with `ev_ack_done_i` high. Otherwise it holds.
- R3: Bit 14 (master transmit busy) is set by `ev_mtx_begin_i` and cleared by `ev_ack_done_i`. When both arrive in the same cycle, the set wins.
- R4: Bit 10 (bus collision) is set by `ev_collide_i` and stays set until software writes 0 to bit 10. Writing 1 to bit 10 leaves it unchanged.
- R5: Bit 9 (general call) is set by `ev_gcall_i` and bit 8 (10-bit match) is set by `ev_addr10_i`. `ev_stop_i` clears both. A set wins over a Stop in the same cycle.
- R6: A host write (`host_tx_wr_i`) while `core_busy_i` is high or bit 0 is already 1 sets bit 7 (write collision). Such a write is discarded and changes neither bit 0 nor bit 5. Only a software write of 0 to bit 7 clears bit 7.
- R7: `ev_rx_byte_i` while bit 1 is 1 and `host_rx_rd_i` is low sets bit 6 (receive overflow), and bit 1 stays 1. Only a software write of 0 to bit 6 clears bit 6. A read in the same cycle avoids the overflow.
- R8: Bit 5 (data/address) is cleared by `ev_addr_match_i`. It is set by an accepted host write, or by `ev_rx_byte_i` while `slave_role_i` is 1. A received byte with `slave_role_i` at 0 leaves it unchanged. The clear wins over a set in the same cycle.
- R9: `ev_start_i` or `ev_rstart_i` sets bit 3 (Start) and clears bit 4 (Stop). `ev_stop_i` sets bit 4 and clears bit 3. When both kinds arrive in the same cycle, the Stop wins. Bits 3 and 4 are never both 1.
- R10: Bit 1 (receive buffer full) is set by `ev_rx_byte_i` and cleared by `host_rx_rd_i`. A new byte wins over a read in the same cycle.
- R11: Bit 0 (transmit buffer full) is set by an accepted host write and cleared by `ev_tx_load_i`. An accepted write wins over a load in the same cycle.
- R12: Software writes (`sw_wr_en_i`) can only clear bits 10, 7 and 6, and only where `sw_wr_data_i` holds 0. Every other bit ignores the write. A hardware set of one of those three flags wins over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start_i | input | 1 | Start condition detected |
| ev_rstart_i | input | 1 | Repeated Start detected |
| ev_stop_i | input | 1 | Stop condition detected |
| ev_ack_done_i | input | 1 | End of an acknowledge slot |
| ack_nack_i | input | 1 | Sampled acknowledge level, 1 = NACK |
| ev_mtx_begin_i | input | 1 | Master transmission begins |
| ev_collide_i | input | 1 | Bus collision during a master operation |
| ev_gcall_i | input | 1 | General call address matched |
| ev_addr10_i | input | 1 | Second byte of a 10-bit address matched |
| ev_addr_match_i | input | 1 | Device address matched |
| ev_rx_byte_i | input | 1 | Received byte ready to move into the receive holding register |
| slave_role_i | input | 1 | Controller is operating as slave |
| ev_tx_load_i | input | 1 | Transmit holding byte moved into the shift register |
| host_tx_wr_i | input | 1 | Host writes the transmit holding register |
| core_busy_i | input | 1 | Controller busy, so transmit writes collide |
| host_rx_rd_i | input | 1 | Host reads the receive holding register |
| sw_wr_en_i | input | 1 | Software write strobe for the status word |
| sw_wr_data_i | input | REG_W | Software write data (0 clears a clearable flag) |
| rd_data_o | output | REG_W | Status word read port |

## Verification
The bench builds the block with its default `REG_W` of 16. That value is the only width the fixed bit layout supports, so it brings every flag position, including the unimplemented holes, within reach of the word-level checks. The directed scenarios target the same-cycle collisions that decide priority: set against Stop, hardware set against software clear, address match against slave reception, Start against Stop, and a read against a new byte. They also cover the discarded host write under both busy and buffer-full conditions.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned STAT_W = 16;

  // bit positions in the status word
  localparam int unsigned B_ACK   = 15;
  localparam int unsigned B_TRX   = 14;
  localparam int unsigned B_BCOL  = 10;
  localparam int unsigned B_GCALL = 9;
  localparam int unsigned B_A10   = 8;
  localparam int unsigned B_WCOL  = 7;
  localparam int unsigned B_OVF   = 6;
  localparam int unsigned B_DA    = 5;
  localparam int unsigned B_STOP  = 4;
  localparam int unsigned B_START = 3;
  localparam int unsigned B_RBF   = 1;
  localparam int unsigned B_TBF   = 0;

  // index of each set/clear flag cell
  typedef enum logic [2:0] {
    F_TRX   = 3'd0,
    F_BCOL  = 3'd1,
    F_GCALL = 3'd2,
    F_A10   = 3'd3,
    F_WCOL  = 3'd4,
    F_OVF   = 3'd5
  } flag_idx_e;
  localparam int unsigned NUM_FLAGS = 6;
endpackage

// File: rtl/i2c_stat_flag.sv
// One flag with a set input that wins over a clear input.
module i2c_stat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_stat_bufs.sv
// Holding register occupancy plus the collision and overflow events.
module i2c_stat_bufs (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_byte_i,
  input  logic rx_rd_i,
  input  logic tx_wr_i,
  input  logic busy_i,
  input  logic tx_load_i,
  output logic rbf_o,
  output logic tbf_o,
  output logic ovf_evt_o,
  output logic wcol_evt_o,
  output logic tx_accept_o
);
  logic rbf_q, tbf_q;

  // a byte arriving while the previous one is still unread and not being read
  assign ovf_evt_o   = rx_byte_i && rbf_q && !rx_rd_i;
  assign wcol_evt_o  = tx_wr_i && (busy_i || tbf_q);
  assign tx_accept_o = tx_wr_i && !busy_i && !tbf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbf_q <= 1'b0;
      tbf_q <= 1'b0;
    end else begin
      if (rx_byte_i)    rbf_q <= 1'b1;
      else if (rx_rd_i) rbf_q <= 1'b0;
      if (tx_accept_o)    tbf_q <= 1'b1;
      else if (tx_load_i) tbf_q <= 1'b0;
    end
  end

  assign rbf_o = rbf_q;
  assign tbf_o = tbf_q;
endmodule

// File: rtl/i2c_stat_bus.sv
// Bus-condition flags: Start/Stop pair, acknowledge result, data/address.
module i2c_stat_bus (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rstart_i,
  input  logic stop_i,
  input  logic ack_done_i,
  input  logic nack_i,
  input  logic addr_match_i,
  input  logic tx_accept_i,
  input  logic rx_byte_i,
  input  logic slave_i,
  output logic start_o,
  output logic stop_o,
  output logic ack_o,
  output logic da_o
);
  logic any_start;
  logic da_set;

  assign any_start = start_i || rstart_i;
  assign da_set    = tx_accept_i || (rx_byte_i && slave_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      ack_o   <= 1'b0;
      da_o    <= 1'b0;
    end else begin
      // Stop is the later condition, so it wins a same-cycle tie
      if (stop_i) begin
        stop_o  <= 1'b1;
        start_o <= 1'b0;
      end else if (any_start) begin
        start_o <= 1'b1;
        stop_o  <= 1'b0;
      end
      if (ack_done_i) ack_o <= nack_i;
      // an address match marks the byte as address, overriding a set
      if (addr_match_i) da_o <= 1'b0;
      else if (da_set)  da_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
#(
  parameter int unsigned REG_W = STAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_i,
  input  logic             ev_rstart_i,
  input  logic             ev_stop_i,
  input  logic             ev_ack_done_i,
  input  logic             ack_nack_i,
  input  logic             ev_mtx_begin_i,
  input  logic             ev_collide_i,
  input  logic             ev_gcall_i,
  input  logic             ev_addr10_i,
  input  logic             ev_addr_match_i,
  input  logic             ev_rx_byte_i,
  input  logic             slave_role_i,
  input  logic             ev_tx_load_i,
  input  logic             host_tx_wr_i,
  input  logic             core_busy_i,
  input  logic             host_rx_rd_i,
  input  logic             sw_wr_en_i,
  input  logic [REG_W-1:0] sw_wr_data_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic [NUM_FLAGS-1:0] f_set, f_clr, f_q;
  logic rbf, tbf, ovf_evt, wcol_evt, tx_accept;
  logic s_q, p_q, ack_q, da_q;
  logic sw_clr_bcol, sw_clr_wcol, sw_clr_ovf;

  assign sw_clr_bcol = sw_wr_en_i && !sw_wr_data_i[B_BCOL];
  assign sw_clr_wcol = sw_wr_en_i && !sw_wr_data_i[B_WCOL];
  assign sw_clr_ovf  = sw_wr_en_i && !sw_wr_data_i[B_OVF];

  i2c_stat_bufs u_bufs (
    .clk(clk), .rst_n(rst_n),
    .rx_byte_i(ev_rx_byte_i), .rx_rd_i(host_rx_rd_i),
    .tx_wr_i(host_tx_wr_i), .busy_i(core_busy_i), .tx_load_i(ev_tx_load_i),
    .rbf_o(rbf), .tbf_o(tbf), .ovf_evt_o(ovf_evt),
    .wcol_evt_o(wcol_evt), .tx_accept_o(tx_accept)
  );

  i2c_stat_bus u_bus (
    .clk(clk), .rst_n(rst_n),
    .start_i(ev_start_i), .rstart_i(ev_rstart_i), .stop_i(ev_stop_i),
    .ack_done_i(ev_ack_done_i), .nack_i(ack_nack_i),
    .addr_match_i(ev_addr_match_i), .tx_accept_i(tx_accept),
    .rx_byte_i(ev_rx_byte_i), .slave_i(slave_role_i),
    .start_o(s_q), .stop_o(p_q), .ack_o(ack_q), .da_o(da_q)
  );

  always_comb begin
    f_set = '0;
    f_clr = '0;
    f_set[F_TRX]   = ev_mtx_begin_i;
    f_clr[F_TRX]   = ev_ack_done_i;
    f_set[F_BCOL]  = ev_collide_i;
    f_clr[F_BCOL]  = sw_clr_bcol;
    f_set[F_GCALL] = ev_gcall_i;
    f_clr[F_GCALL] = ev_stop_i;
    f_set[F_A10]   = ev_addr10_i;
    f_clr[F_A10]   = ev_stop_i;
    f_set[F_WCOL]  = wcol_evt;
    f_clr[F_WCOL]  = sw_clr_wcol;
    f_set[F_OVF]   = ovf_evt;
    f_clr[F_OVF]   = sw_clr_ovf;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    i2c_stat_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_i(f_set[g]), .clr_i(f_clr[g]), .q_o(f_q[g])
    );
  end

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[B_ACK]   = ack_q;
    rd_data_o[B_TRX]   = f_q[F_TRX];
    rd_data_o[B_BCOL]  = f_q[F_BCOL];
    rd_data_o[B_GCALL] = f_q[F_GCALL];
    rd_data_o[B_A10]   = f_q[F_A10];
    rd_data_o[B_WCOL]  = f_q[F_WCOL];
    rd_data_o[B_OVF]   = f_q[F_OVF];
    rd_data_o[B_DA]    = da_q;
    rd_data_o[B_STOP]  = p_q;
    rd_data_o[B_START] = s_q;
    rd_data_o[B_RBF]   = rbf;
    rd_data_o[B_TBF]   = tbf;
  end
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk #(
  parameter int unsigned REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_start_i,
  input logic             ev_stop_i,
  input logic             ev_ack_done_i,
  input logic             ack_nack_i,
  input logic             ev_collide_i,
  input logic             ev_gcall_i,
  input logic             ev_rx_byte_i,
  input logic             host_tx_wr_i,
  input logic             core_busy_i,
  input logic             host_rx_rd_i,
  input logic             sw_wr_en_i,
  input logic [REG_W-1:0] sw_wr_data_i,
  input logic [REG_W-1:0] rd_data_o
);
  a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_done_i |=> rd_data_o[15] == $past(ack_nack_i));

  a_r4_bcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[10] && !(sw_wr_en_i && !sw_wr_data_i[10])) |=> rd_data_o[10]);

  a_r5_gcall_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop_i && !ev_gcall_i) |=> !rd_data_o[9]);

  a_r6_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_wr_i && core_busy_i) |=> rd_data_o[7]);

  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_byte_i && rd_data_o[1] && !host_rx_rd_i) |=> (rd_data_o[6] && rd_data_o[1]));

  a_r9_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_data_o[4:3]) <= 1);

  a_r9_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_i && !ev_stop_i) |=> (rd_data_o[3] && !rd_data_o[4]));

  a_r12_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_collide_i && sw_wr_en_i && !sw_wr_data_i[10]) |=> rd_data_o[10]);
endmodule

bind i2c_stat_reg i2c_stat_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_start_i(ev_start_i), .ev_stop_i(ev_stop_i),
  .ev_ack_done_i(ev_ack_done_i), .ack_nack_i(ack_nack_i),
  .ev_collide_i(ev_collide_i), .ev_gcall_i(ev_gcall_i),
  .ev_rx_byte_i(ev_rx_byte_i), .host_tx_wr_i(host_tx_wr_i),
  .core_busy_i(core_busy_i), .host_rx_rd_i(host_rx_rd_i),
  .sw_wr_en_i(sw_wr_en_i), .sw_wr_data_i(sw_wr_data_i),
  .rd_data_o(rd_data_o)
);

// File: tb/test_i2c_stat_reg.sv
`timescale 1ns/1ps
module test_i2c_stat_reg;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start, ev_rstart, ev_stop, ev_ack, nack, ev_mtx, ev_col;
  logic ev_gc, ev_a10, ev_am, ev_rx, slave, ev_ld, tx_wr, busy, rx_rd, sw_en;
  logic [W-1:0] sw_d;
  logic [W-1:0] rd;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  i2c_stat_reg i_i2c_stat_reg (
    .clk(clk), .rst_n(rst_n),
    .ev_start_i(ev_start), .ev_rstart_i(ev_rstart), .ev_stop_i(ev_stop),
    .ev_ack_done_i(ev_ack), .ack_nack_i(nack), .ev_mtx_begin_i(ev_mtx),
    .ev_collide_i(ev_col), .ev_gcall_i(ev_gc), .ev_addr10_i(ev_a10),
    .ev_addr_match_i(ev_am), .ev_rx_byte_i(ev_rx), .slave_role_i(slave),
    .ev_tx_load_i(ev_ld), .host_tx_wr_i(tx_wr), .core_busy_i(busy),
    .host_rx_rd_i(rx_rd), .sw_wr_en_i(sw_en), .sw_wr_data_i(sw_d),
    .rd_data_o(rd)
  );

  task automatic idle_inputs();
    {ev_start, ev_rstart, ev_stop, ev_ack, nack, ev_mtx, ev_col} = '0;
    {ev_gc, ev_a10, ev_am, ev_rx, slave, ev_ld, tx_wr, busy, rx_rd, sw_en} = '0;
    sw_d = '0;
  endtask

  // inputs are applied at a falling edge; this captures them and clears them
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_bit(string tag, int idx, logic exp);
    n_chk++;
    if (rd[idx] !== exp) begin
      n_bad++;
      $display("FAIL %s bit%0d actual=%0b expected=%0b", tag, idx, rd[idx], exp);
    end
  endtask

  task automatic chk_word(string tag, logic [W-1:0] exp);
    n_chk++;
    if (rd !== exp) begin
      n_bad++;
      $display("FAIL %s word actual=%h expected=%h", tag, rd, exp);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk_word("R1 reset", 16'h0000);
  endtask

  task automatic t_ack();
    do_reset();
    ev_ack = 1; nack = 1; step();
    chk_bit("R2 nack", 15, 1'b1);
    nack = 1; step();
    chk_bit("R2 hold without strobe", 15, 1'b1);
    ev_ack = 1; nack = 0; step();
    chk_bit("R2 ack", 15, 1'b0);
  endtask

  task automatic t_trx();
    do_reset();
    ev_mtx = 1; step();
    chk_bit("R3 begin", 14, 1'b1);
    step();
    chk_bit("R3 hold", 14, 1'b1);
    ev_ack = 1; step();
    chk_bit("R3 end at ack", 14, 1'b0);
    ev_mtx = 1; ev_ack = 1; step();
    chk_bit("R3 set wins", 14, 1'b1);
  endtask

  task automatic t_bcol();
    do_reset();
    ev_col = 1; step();
    chk_bit("R4 set", 10, 1'b1);
    sw_en = 1; sw_d = 16'hFFFF; step();
    chk_bit("R4 write one keeps", 10, 1'b1);
    sw_en = 1; sw_d = 16'hFBFF; step();
    chk_bit("R4 write zero clears", 10, 1'b0);
    ev_col = 1; sw_en = 1; sw_d = 16'h0000; step();
    chk_bit("R12 hw set beats sw clear", 10, 1'b1);
  endtask

  task automatic t_gcall();
    do_reset();
    ev_gc = 1; step();
    chk_bit("R5 gcall", 9, 1'b1);
    ev_a10 = 1; step();
    chk_bit("R5 addr10", 8, 1'b1);
    sw_en = 1; sw_d = 16'h0000; step();
    chk_word("R12 sw cannot clear 9/8", 16'h0300);
    ev_stop = 1; step();
    chk_bit("R5 stop clears gcall", 9, 1'b0);
    chk_bit("R5 stop clears addr10", 8, 1'b0);
    ev_gc = 1; ev_stop = 1; step();
    chk_bit("R5 set beats stop", 9, 1'b1);
  endtask

  task automatic t_wcol();
    do_reset();
    tx_wr = 1; busy = 1; step();
    chk_bit("R6 busy write collides", 7, 1'b0 | 1'b1);
    chk_bit("R6 discarded no tbf", 0, 1'b0);
    chk_bit("R6 discarded no da", 5, 1'b0);
    sw_en = 1; sw_d = 16'hFF7F; step();
    chk_bit("R6 sw clear", 7, 1'b0);
    tx_wr = 1; step();
    chk_bit("R6 accepted no collision", 7, 1'b0);
    chk_bit("R11 accepted sets tbf", 0, 1'b1);
    chk_bit("R8 accepted sets da", 5, 1'b1);
    tx_wr = 1; step();
    chk_bit("R6 full write collides", 7, 1'b1);
    chk_bit("R6 tbf still full", 0, 1'b1);
  endtask

  task automatic t_ovf();
    do_reset();
    ev_rx = 1; step();
    chk_bit("R10 rx sets rbf", 1, 1'b1);
    chk_bit("R7 no overflow on first", 6, 1'b0);
    ev_rx = 1; step();
    chk_bit("R7 overflow", 6, 1'b1);
    chk_bit("R7 rbf stays", 1, 1'b1);
    sw_en = 1; sw_d = 16'hFFBF; step();
    chk_bit("R7 sw clear", 6, 1'b0);
    ev_rx = 1; rx_rd = 1; step();
    chk_bit("R7 read same cycle avoids", 6, 1'b0);
    chk_bit("R10 new byte beats read", 1, 1'b1);
    rx_rd = 1; step();
    chk_bit("R10 read clears", 1, 1'b0);
  endtask

  task automatic t_da();
    do_reset();
    ev_rx = 1; slave = 1; step();
    chk_bit("R8 slave rx sets", 5, 1'b1);
    ev_am = 1; step();
    chk_bit("R8 addr match clears", 5, 1'b0);
    ev_am = 1; ev_rx = 1; slave = 1; step();
    chk_bit("R8 clear beats set", 5, 1'b0);
    ev_rx = 1; slave = 0; step();
    chk_bit("R8 master rx no effect", 5, 1'b0);
  endtask

  task automatic t_startstop();
    do_reset();
    ev_start = 1; step();
    chk_word("R9 start", 16'h0008);
    ev_stop = 1; step();
    chk_word("R9 stop", 16'h0010);
    ev_rstart = 1; step();
    chk_word("R9 rstart", 16'h0008);
    ev_start = 1; ev_stop = 1; step();
    chk_word("R9 stop wins", 16'h0010);
  endtask

  task automatic t_tbf();
    do_reset();
    tx_wr = 1; step();
    chk_bit("R11 set", 0, 1'b1);
    ev_ld = 1; step();
    chk_bit("R11 load clears", 0, 1'b0);
    tx_wr = 1; ev_ld = 1; step();
    chk_bit("R11 write beats load", 0, 1'b1);
  endtask

  task automatic t_swignore();
    do_reset();
    ev_ack = 1; nack = 1; ev_start = 1; ev_mtx = 1; step();
    sw_en = 1; sw_d = 16'h0000; step();
    chk_word("R12 hw-only bits ignore write", 16'hC008);
    do_reset();
    sw_en = 1; sw_d = 16'hFFFF; step();
    chk_word("R12 write ones sets nothing", 16'h0000);
    chk_word("R1 holes stay zero", 16'h0000);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    t_reset();
    t_ack();
    t_trx();
    t_bcol();
    t_gcall();
    t_wcol();
    t_ovf();
    t_da();
    t_startstop();
    t_tbf();
    t_swignore();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule